// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs the iteration loop of a string instruction that carries a repeat prefix. On a start pulse it captures three things from the decoder: the prefix code, the kind of string instruction and the effective address size. It also captures the initial value of the count register. It then requests one element operation at a time from the string datapath. Each request waits for a ready handshake, so an element may take any number of cycles.

After each completed element, the block decrements the active low part of the count register. The width of that part is 16, 32 or 64 bits and follows the address size. The block then decides whether to stop. For the plain forms only the count matters. For the compare and scan kinds, the zero flag that the datapath returns with the handshake also matters, and the prefix code gives its sense.

When the loop ends, a one-cycle done pulse is raised and the final count stays visible on `count_out`. A prefix and instruction pairing that is not allowed is reported together with done, and no element is requested. An instruction kind with no repeat behaviour runs exactly once.

Top module: `rsq_rep_seq`

## Requirements
- R1: After synchronous reset, `step_req`, `done`, `illegal` and `busy` are 0 and `count_out` is 0.
- R2: With prefix code 0 (no repeat), exactly one element is requested and `count_out` keeps the loaded count.
- R3: With prefix code 1 on kinds 0 to 4 (move, store, load, port-in, port-out), one element runs per count unit, the final count is 0 and `zf_in` has no effect.
- R4: A repeat form whose active count is 0 at start requests no element, raises `done` in the cycle after start, and leaves the count unchanged.
- R5: With prefix code 1 on kind 5 (compare) or 6 (scan), the loop stops after the element where the count reaches 0 or `zf_in` is 0.
- R6: With prefix code 2 on kind 5 or 6, the loop stops after the element where the count reaches 0 or `zf_in` is 1.
- R7: Prefix code 2 on any kind other than 5 or 6, or prefix code 3 on any kind, raises `illegal` with `done`, requests no element and leaves the count unchanged.
- R8: Prefix code 1 on kind 7 (no repeat behaviour) runs exactly one element and leaves the count unchanged.
- R9: Address size 0, 1 and 2 select 16-, 32- and 64-bit active count widths, and code 3 selects 64 bits. The decrement and the zero test use only the active bits, and bits above them are preserved.
- R10: `step_req` stays high until `step_ready` is seen, and the count changes only in the cycle after a handshake.
- R11: A start pulse while `busy` is high is ignored.
- R12: `done` is a single-cycle pulse that never coincides with `step_req`, and `illegal` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| pfx_code | input | 2 | 0 none, 1 repeat / repeat-while-equal, 2 repeat-while-not-equal, 3 reserved |
| op_kind | input | 3 | 0 move, 1 store, 2 load, 3 port-in, 4 port-out, 5 compare, 6 scan, 7 other |
| addr_size | input | 2 | 0 16-bit, 1 32-bit, 2 and 3 64-bit |
| count_in | input | CNT_W | Initial count register value |
| step_ready | input | 1 | Datapath finished the current element |
| zf_in | input | 1 | Zero flag of the element finishing with `step_ready` |
| step_req | output | 1 | Request for one element operation |
| done | output | 1 | Operation complete (one cycle) |
| illegal | output | 1 | Prefix and kind pairing not allowed (with `done`) |
| busy | output | 1 | Loop in progress |
| count_out | output | CNT_W | Current count register |

## Verification
The bench sweeps every prefix code against every instruction kind, with counts from 0 to 3 and with datapath latencies of 0 to 2 wait cycles. On the compare and scan kinds, the zero flag is set to hit its terminating value at the first element, at the second element, or never, so that a zero-flag stop can be told apart from a count-exhaustion stop. The plain kinds get an alternating zero flag, so a stray flag dependence would change their element count. Separate cases load counts with nonzero bits above the active width, and counts whose active part is 0 while upper bits are set. These cases tell the three widths apart and show that a borrow does not cross the width boundary. One case pulses start in the middle of a loop.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    PFX_NONE  = 2'd0,
    PFX_REP   = 2'd1,
    PFX_REPNE = 2'd2,
    PFX_RSVD  = 2'd3
  } pfx_e;

  typedef enum logic [2:0] {
    K_MOVE  = 3'd0,
    K_STORE = 3'd1,
    K_LOAD  = 3'd2,
    K_PIN   = 3'd3,
    K_POUT  = 3'd4,
    K_CMP   = 3'd5,
    K_SCAN  = 3'd6,
    K_OTHER = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    ASZ_16  = 2'd0,
    ASZ_32  = 2'd1,
    ASZ_64  = 2'd2,
    ASZ_RSV = 2'd3
  } asz_e;

  typedef enum logic [1:0] {
    M_ONCE     = 2'd0,
    M_PLAIN    = 2'd1,
    M_WHILE_EQ = 2'd2,
    M_WHILE_NE = 2'd3
  } mode_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/rsq_decode.sv
module rsq_decode
  import rsq_pkg::*;
(
  input  pfx_e  pfx,
  input  kind_e kind,
  output logic  bad_pair,
  output mode_e mode
);
  logic is_cmp;

  assign is_cmp = (kind == K_CMP) || (kind == K_SCAN);

  always_comb begin
    bad_pair = 1'b0;
    mode     = M_ONCE;
    unique case (pfx)
      PFX_NONE: mode = M_ONCE;
      PFX_REP: begin
        if (kind == K_OTHER) mode = M_ONCE;
        else if (is_cmp)     mode = M_WHILE_EQ;
        else                 mode = M_PLAIN;
      end
      PFX_REPNE: begin
        if (is_cmp) mode = M_WHILE_NE;
        else        bad_pair = 1'b1;
      end
      default: bad_pair = 1'b1;
    endcase
  end
endmodule

// File: rtl/rsq_count.sv
module rsq_count
  import rsq_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 16,
  parameter int MID_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  asz_e             asz,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  output logic [CNT_W-1:0] cnt,
  output logic             load_zero,
  output logic             one_left
);
  localparam logic [CNT_W-1:0] MASK_N = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [CNT_W-1:0] MASK_M = {{(CNT_W-MID_W){1'b0}}, {MID_W{1'b1}}};
  localparam logic [CNT_W-1:0] MASK_F = {CNT_W{1'b1}};

  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    unique case (asz)
      ASZ_16:  mask = MASK_N;
      ASZ_32:  mask = MASK_M;
      default: mask = MASK_F;
    endcase
  end

  assign load_zero = ((load_val & mask) == '0);
  assign one_left  = ((cnt_q & mask) == CNT_W'(1));
  assign cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec_en) begin
      cnt_q <= (cnt_q & ~mask) | ((cnt_q - CNT_W'(1)) & mask);
    end
  end

  // R9
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !load && asz == ASZ_16) |=> $stable(cnt_q[CNT_W-1:NARROW_W]));

  // R3
  low_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !load && asz == ASZ_16) |=>
      cnt_q[NARROW_W-1:0] == $past(cnt_q[NARROW_W-1:0]) - NARROW_W'(1));
endmodule

// File: rtl/rsq_term.sv
module rsq_term
  import rsq_pkg::*;
(
  input  mode_e mode,
  input  logic  zf,
  input  logic  one_left,
  output logic  stop
);
  always_comb begin
    unique case (mode)
      M_ONCE:     stop = 1'b1;
      M_PLAIN:    stop = one_left;
      M_WHILE_EQ: stop = one_left || !zf;
      default:    stop = one_left || zf;
    endcase
  end
endmodule

// File: rtl/rsq_rep_seq.sv
module rsq_rep_seq
  import rsq_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 16,
  parameter int MID_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       pfx_code,
  input  logic [2:0]       op_kind,
  input  logic [1:0]       addr_size,
  input  logic [CNT_W-1:0] count_in,
  input  logic             step_ready,
  input  logic             zf_in,
  output logic             step_req,
  output logic             done,
  output logic             illegal,
  output logic             busy,
  output logic [CNT_W-1:0] count_out
);
  state_e state_q;
  mode_e  mode_q, dec_mode;
  asz_e   asz_q, asz_use;
  logic   step_q, done_q, ill_q;
  logic   bad_pair, load_zero, one_left, stop;
  logic   accept, dec_en;

  rsq_decode u_dec (
    .pfx      (pfx_e'(pfx_code)),
    .kind     (kind_e'(op_kind)),
    .bad_pair (bad_pair),
    .mode     (dec_mode)
  );

  assign accept  = (state_q == S_IDLE) && start;
  assign asz_use = (state_q == S_IDLE) ? asz_e'(addr_size) : asz_q;
  assign dec_en  = (state_q == S_RUN) && step_ready && (mode_q != M_ONCE);

  rsq_count #(
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W),
    .MID_W    (MID_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .asz       (asz_use),
    .load      (accept),
    .load_val  (count_in),
    .dec_en    (dec_en),
    .cnt       (count_out),
    .load_zero (load_zero),
    .one_left  (one_left)
  );

  rsq_term u_term (
    .mode     (mode_q),
    .zf       (zf_in),
    .one_left (one_left),
    .stop     (stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      mode_q  <= M_ONCE;
      asz_q   <= ASZ_16;
      step_q  <= 1'b0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            asz_q  <= asz_e'(addr_size);
            mode_q <= dec_mode;
            if (bad_pair) begin
              done_q <= 1'b1;
              ill_q  <= 1'b1;
            end else if (dec_mode != M_ONCE && load_zero) begin
              done_q <= 1'b1;
            end else begin
              step_q  <= 1'b1;
              state_q <= S_RUN;
            end
          end
        end
        default: begin
          if (step_ready && stop) begin
            step_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
      endcase
    end
  end

  assign step_req = step_q;
  assign done     = done_q;
  assign illegal  = ill_q;
  assign busy     = (state_q == S_RUN);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_req && !step_ready) |=> step_req);

  // R10
  cnt_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !step_ready) |=> $stable(count_out));

  // R12
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && step_req));

  // R12
  ill_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);

  // R4
  zero_start_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !bad_pair && dec_mode != M_ONCE && load_zero) |=> (done && !step_req));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !step_ready) |=> (busy && $stable(count_out)));
endmodule

// File: tb/tb_rsq_rep_seq.sv
`timescale 1ns/1ps
module tb_rsq_rep_seq;
  localparam int CW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    pfx_code = '0;
  logic [2:0]    op_kind = '0;
  logic [1:0]    addr_size = '0;
  logic [CW-1:0] count_in = '0;
  logic          step_ready = 1'b0;
  logic          zf_in = 1'b0;
  logic          step_req, done, illegal, busy;
  logic [CW-1:0] count_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rsq_rep_seq dut (
    .clk(clk), .rst(rst), .start(start), .pfx_code(pfx_code), .op_kind(op_kind),
    .addr_size(addr_size), .count_in(count_in), .step_ready(step_ready), .zf_in(zf_in),
    .step_req(step_req), .done(done), .illegal(illegal), .busy(busy), .count_out(count_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] mask_of(input logic [1:0] a);
    if (a == 2'd0) return 64'h0000_0000_0000_FFFF;
    if (a == 2'd1) return 64'h0000_0000_FFFF_FFFF;
    return '1;
  endfunction

  function automatic bit is_cmp(input logic [2:0] k);
    return (k == 3'd5) || (k == 3'd6);
  endfunction

  function automatic logic zf_for(input logic [1:0] p, input logic [2:0] k,
                                  input int it, input int stop_it);
    logic term;
    if (!is_cmp(k)) return it[0];
    term = (p == 2'd1) ? 1'b0 : 1'b1;
    return (it == stop_it) ? term : !term;
  endfunction

  task automatic run_op(input logic [1:0] p, input logic [2:0] k, input logic [1:0] a,
                        input logic [CW-1:0] c, input int stop_it, input int lat,
                        input bit poke, input string force_tag);
    logic [CW-1:0] m, act_low, exp_cnt;
    bit exp_ill, seen, ill_bad, stable_bad, hs_prev, zero_start;
    int exp_steps, steps, wt, cyc;
    string tag;
    logic [CW-1:0] prev_cnt;

    m = mask_of(a);
    exp_ill = (p == 2'd3) || (p == 2'd2 && !is_cmp(k));
    exp_steps = 0;
    exp_cnt = c;
    zero_start = 1'b0;
    if (exp_ill) tag = "R7";
    else if (p == 2'd0) tag = "R2";
    else if (k == 3'd7) tag = "R8";
    else if ((c & m) == '0) tag = "R4";
    else if (is_cmp(k) && p == 2'd1) tag = "R5";
    else if (is_cmp(k)) tag = "R6";
    else tag = "R3";
    if (force_tag != "") tag = force_tag;

    if (exp_ill) exp_steps = 0;
    else if (p == 2'd0 || k == 3'd7) exp_steps = 1;
    else if ((c & m) == '0) zero_start = 1'b1;
    else begin
      act_low = c & m;
      for (int it = 0; it < 100000; it++) begin
        exp_steps++;
        act_low = (act_low - 1) & m;
        if (act_low == '0) break;
        if (is_cmp(k) && zf_for(p, k, it, stop_it) == ((p == 2'd1) ? 1'b0 : 1'b1)) break;
      end
      exp_cnt = (c & ~m) | act_low;
    end

    pfx_code = p; op_kind = k; addr_size = a; count_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    steps = 0; wt = 0; cyc = 0; seen = 0; ill_bad = 0; stable_bad = 0; hs_prev = 0;
    prev_cnt = count_out;
    while (cyc < 2000) begin
      if (done) begin seen = 1; break; end
      if (illegal) ill_bad = 1;
      if (busy && !hs_prev && cyc > 0 && count_out != prev_cnt) stable_bad = 1;
      prev_cnt = count_out;
      hs_prev = 0;
      step_ready = 1'b0;
      start = 1'b0;
      if (poke && cyc == 3) begin start = 1'b1; count_in = 64'h00FF; end
      if (step_req) begin
        if (wt >= lat) begin
          step_ready = 1'b1;
          zf_in = zf_for(p, k, steps, stop_it);
          steps++;
          hs_prev = 1;
          wt = 0;
        end else wt++;
      end
      @(negedge clk);
      cyc++;
    end
    step_ready = 1'b0;
    start = 1'b0;
    chk(seen, tag, "done seen", CW'(seen), 1);
    chk(illegal == exp_ill, tag, "illegal flag", CW'(illegal), CW'(exp_ill));
    chk(steps == exp_steps, tag, "element count", CW'(steps), CW'(exp_steps));
    chk(count_out == exp_cnt, tag, "final count", count_out, exp_cnt);
    if (zero_start) chk(cyc == 0, "R4", "done latency", CW'(cyc), 0);
    chk(!ill_bad, "R12", "illegal without done", CW'(ill_bad), 0);
    chk(!stable_bad, "R10", "count moved without handshake", CW'(stable_bad), 0);
    @(negedge clk);
    chk(!done, "R12", "done width", CW'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!step_req && !done && !illegal && !busy, "R1", "control outputs",
        CW'({step_req, done, illegal, busy}), 0);
    chk(count_out == '0, "R1", "count", count_out, 0);

    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++)
        for (int c = 0; c < 4; c++)
          for (int s = 0; s < 3; s++)
            run_op(2'(p), 3'(k), 2'd0, CW'(c), (s == 2) ? 50 : s, (c + k + s) % 3, 1'b0, "");

    // R9 width selection and upper-bit preservation
    run_op(2'd1, 3'd0, 2'd0, 64'h0000_0001_0000_0002, 0, 1, 1'b0, "R9");
    run_op(2'd1, 3'd1, 2'd0, 64'h0000_0000_0001_0000, 0, 0, 1'b0, "R9");
    run_op(2'd1, 3'd2, 2'd1, 64'hFFFF_FFFF_0000_0003, 0, 2, 1'b0, "R9");
    run_op(2'd1, 3'd0, 2'd2, 64'd5, 0, 0, 1'b0, "R9");
    run_op(2'd1, 3'd5, 2'd2, 64'h0000_0001_0000_0000, 0, 1, 1'b0, "R9");
    run_op(2'd1, 3'd5, 2'd1, 64'h0000_0001_0000_0000, 0, 1, 1'b0, "R9");
    run_op(2'd1, 3'd6, 2'd3, 64'h0000_0001_0000_0000, 0, 0, 1'b0, "R9");
    run_op(2'd2, 3'd6, 2'd0, 64'h0000_0000_0003_0001, 50, 0, 1'b0, "R9");
    run_op(2'd2, 3'd5, 2'd1, 64'h0000_0000_0001_0000, 0, 1, 1'b0, "R9");

    // R11 start during a running loop
    run_op(2'd1, 3'd0, 2'd0, 64'd6, 0, 2, 1'b1, "R11");
    // R10 long waits between handshakes
    run_op(2'd2, 3'd5, 2'd0, 64'd3, 50, 7, 1'b0, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule